// File: doc/BRIEF.md
# Parallel Configuration Byte Receiver

This block is the target side of an asynchronous, byte-wide configuration port. A host sees a chip-select pair, a write strobe, a read strobe, an eight-bit data bus, a configuration-reset input, an open-drain status line and a ready/busy line. Inside, every strobe and the data bus are brought into the internal clock domain through two-flop synchronizers. All decisions are then made on the synchronized copies.

The control machine has three states. `ST_HOLD` is the configuration reset: the status line is pulled low, ready/busy reads busy and nothing is accepted. The transition `hold_to_ready` happens once the synchronized configuration-reset input is high. It releases the status line and raises ready. In `ST_READY` a rising write strobe seen while the block is selected takes the transition `ready_to_busy`. The byte held on the bus during the strobe-low phase is then published for one cycle on `byte_o`/`byte_vld_o`, and ready/busy drops. `ST_BUSY` lasts a fixed number of internal clock cycles. The transition `busy_to_ready` then raises ready again. From any state, a low configuration-reset input takes the transition `any_to_hold`.

A host that does not wire up the ready/busy line can pull the read strobe low while the block is selected. The block then enables its driver on data bit 7 and places the ready/busy value there. A write strobe that rises while the block is busy is dropped, and it sets a sticky overrun flag. Only the configuration reset clears that flag.

Top module: `pcfg_byte_rx`

## Requirements
- R1: While the configuration-reset input is low (after synchronization), `status_low_o` is 1, `ready_o` is 0, and no write produces a `byte_vld_o` pulse.
- R2: Once the configuration-reset input is high, `status_low_o` returns to 0 and `ready_o` to 1 within three internal clock edges.
- R3: A write is taken only when `sel_n_i` is 0 and `sel_i` is 1 at the strobe's rising edge. In any other case it yields no byte and `ready_o` stays 1.
- R4: An accepted write raises `byte_vld_o` for exactly one cycle, with `byte_o` equal to the value present on `data_i` while the write strobe was low, even if the bus changes together with the rising edge.
- R5: After an accepted write, `ready_o` is 0 for exactly `BUSY_CYCLES` consecutive cycles (default 8), then returns to 1.
- R6: A selected write whose strobe rises while `ready_o` is 0 yields no byte and leaves the busy length unchanged. It sets `overrun_o`, which stays 1 until the configuration-reset input goes low.
- R7: `d7_oe_o` is 1 only while the synchronized read strobe is 0 and the block is selected. While it is 1, `d7_o` carries the ready/busy value (1 = ready).
- R8: A low configuration-reset input during a busy interval aborts it: the block returns to the hold state, with `status_low_o` 1 and `ready_o` 0.
- R9: `ready_o` falls on the third internal clock edge after the write strobe rises (two synchronizer stages, then the state register), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processing clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_rst_n_i | input | 1 | Host configuration reset, low holds the block in hold state |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| wr_n_i | input | 1 | Write strobe, byte taken on its rising edge |
| rd_n_i | input | 1 | Status read strobe, active low |
| data_i | input | 8 | Configuration data bus |
| status_low_o | output | 1 | Open-drain pull-down enable for the status line (1 = pull low) |
| ready_o | output | 1 | Ready/busy line, 1 = ready for a byte |
| d7_o | output | 1 | Value driven on data bit 7 during a status read |
| d7_oe_o | output | 1 | Output enable for data bit 7 |
| byte_o | output | 8 | Captured configuration byte |
| byte_vld_o | output | 1 | One-cycle strobe qualifying `byte_o` |
| overrun_o | output | 1 | Sticky flag: write strobe seen while busy |

## Verification
The main write path is driven with the byte values A5, 3C, FF and 00. With each write, the bus is inverted at the same moment the strobe rises, so a capture taken on the late, synchronized edge is told apart from one taken while the strobe was low. A scoreboard pairs each expected byte with the next `byte_vld_o` pulse, and any pulse with nothing queued counts as a failure. Each write is also timed against the strobe edge. This separates a correct three-edge latency and an eight-cycle busy interval from off-by-one counters. Further patterns exercise: the two half-selected chip-select combinations; a second strobe inside the busy window; status reads in the ready state, in the busy state and while deselected; and a configuration reset in the middle of a busy interval. Together these separate accept, ignore, overrun and abort behaviour.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    // Control states of the byte receiver
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // configuration reset, status pulled low
        ST_READY = 2'd1,   // waiting for a byte
        ST_BUSY  = 2'd2    // processing the last byte
    } cfg_state_e;

    // Bit positions inside the synchronized control bundle
    localparam int CB_CFG  = 0;
    localparam int CB_SELN = 1;
    localparam int CB_SEL  = 2;
    localparam int CB_WRN  = 3;
    localparam int CB_RDN  = 4;
    localparam int CB_W    = 5;

    // Idle level of each control input, used as synchronizer reset value
    localparam logic [CB_W-1:0] CB_IDLE = 5'b11010;

endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
    import pcfg_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_s,       // synchronized configuration reset, high = run
    input  logic sel_ok,      // synchronized chip select qualified
    input  logic wr_n_s,      // synchronized write strobe
    input  logic rd_n_s,      // synchronized read strobe
    output logic accept_o,    // byte taken this cycle
    output logic ready_o,
    output logic status_low_o,
    output logic d7_oe_o,
    output logic overrun_o
);

    localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(BUSY_CYCLES - 1);

    cfg_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          wr_prev_q;
    logic          wr_rise;

    assign wr_rise  = wr_n_s & ~wr_prev_q;
    assign accept_o = (state_q == ST_READY) & wr_rise & sel_ok & cfg_s;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (cfg_s) state_d = ST_READY;                // hold_to_ready
            ST_READY: if (accept_o) state_d = ST_BUSY;              // ready_to_busy
            ST_BUSY:  if (cnt_q == CNT_LAST) state_d = ST_READY;    // busy_to_ready
            default:  state_d = ST_HOLD;
        endcase
        if (!cfg_s) state_d = ST_HOLD;                              // any_to_hold
    end

    // State register, busy counter, edge history, sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_HOLD;
            cnt_q     <= '0;
            wr_prev_q <= 1'b1;
            overrun_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            wr_prev_q <= wr_n_s;
            if (state_q != ST_BUSY) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_HOLD)
                overrun_q <= 1'b0;
            else if ((state_q == ST_BUSY) && wr_rise && sel_ok)
                overrun_q <= 1'b1;
        end
    end

    logic overrun_q;

    // Outputs decoded from state
    always_comb begin
        ready_o      = 1'b0;
        status_low_o = 1'b0;
        unique case (state_q)
            ST_HOLD:  status_low_o = 1'b1;
            ST_READY: ready_o      = 1'b1;
            ST_BUSY:  ready_o      = 1'b0;
            default:  status_low_o = 1'b1;
        endcase
        d7_oe_o   = ~rd_n_s & sel_ok;
        overrun_o = overrun_q;
    end

    AST_HOLD_PULLS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_s |=> (status_low_o && !ready_o)); // R1

    AST_RELEASE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cfg_s) |=> (ready_o && !status_low_o)); // R2

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !ready_o); // R5

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (cnt_q <= CNT_LAST)); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && state_q != ST_HOLD) |=> overrun_o); // R6

    AST_ABORT_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !cfg_s) |=> (state_q == ST_HOLD)); // R8

endmodule

// File: rtl/pcfg_capture.sv
module pcfg_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n_s,
    input  logic          sel_ok,
    input  logic [DW-1:0] data_s,
    input  logic          accept,
    output logic [DW-1:0] byte_o,
    output logic          byte_vld_o
);

    logic [DW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            // track the bus only while the strobe is low and the block selected
            if (!wr_n_s && sel_ok) hold_q <= data_s;
            byte_vld_o <= accept;
            if (accept) byte_o <= hold_q;
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o); // R4

endmodule

// File: rtl/pcfg_byte_rx.sv
module pcfg_byte_rx
    import pcfg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int BUSY_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rst_n_i,
    input  logic          sel_n_i,
    input  logic          sel_i,
    input  logic          wr_n_i,
    input  logic          rd_n_i,
    input  logic [DW-1:0] data_i,
    output logic          status_low_o,
    output logic          ready_o,
    output logic          d7_o,
    output logic          d7_oe_o,
    output logic [DW-1:0] byte_o,
    output logic          byte_vld_o,
    output logic          overrun_o
);

    logic [CB_W-1:0] ctl_raw;
    logic [CB_W-1:0] ctl_s;
    logic [DW-1:0]   data_s;
    logic            sel_ok;
    logic            accept;

    assign ctl_raw[CB_CFG]  = cfg_rst_n_i;
    assign ctl_raw[CB_SELN] = sel_n_i;
    assign ctl_raw[CB_SEL]  = sel_i;
    assign ctl_raw[CB_WRN]  = wr_n_i;
    assign ctl_raw[CB_RDN]  = rd_n_i;

    pcfg_sync #(.W(CB_W), .RST_VAL(CB_IDLE)) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_s)
    );

    pcfg_sync #(.W(DW), .RST_VAL('0)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (data_i),
        .sync_o  (data_s)
    );

    assign sel_ok = ~ctl_s[CB_SELN] & ctl_s[CB_SEL];

    pcfg_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_s        (ctl_s[CB_CFG]),
        .sel_ok       (sel_ok),
        .wr_n_s       (ctl_s[CB_WRN]),
        .rd_n_s       (ctl_s[CB_RDN]),
        .accept_o     (accept),
        .ready_o      (ready_o),
        .status_low_o (status_low_o),
        .d7_oe_o      (d7_oe_o),
        .overrun_o    (overrun_o)
    );

    pcfg_capture #(.DW(DW)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n_s     (ctl_s[CB_WRN]),
        .sel_ok     (sel_ok),
        .data_s     (data_s),
        .accept     (accept),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o)
    );

    // status readback shares bit 7 of the bus
    assign d7_o = ready_o;

    AST_D7_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        d7_oe_o |-> (!$past(rd_n_i, 2) && !$past(sel_n_i, 2) && $past(sel_i, 2))); // R7

endmodule

// File: tb/pcfg_byte_rx_tb.sv
module pcfg_byte_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_rst_n, sel_n, sel, wr_n, rd_n;
    logic [7:0] data;
    logic       status_low, ready, d7, d7_oe, byte_vld, overrun;
    logic [7:0] byte_out;

    int n_checks = 0;
    int n_errors = 0;
    int n_bytes  = 0;
    logic [7:0] exp_q[$];
    logic       rd_oe_smp, rd_d7_smp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_byte_rx #(.DW(8), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rst_n_i(cfg_rst_n),
        .sel_n_i(sel_n), .sel_i(sel), .wr_n_i(wr_n), .rd_n_i(rd_n),
        .data_i(data), .status_low_o(status_low), .ready_o(ready),
        .d7_o(d7), .d7_oe_o(d7_oe), .byte_o(byte_out),
        .byte_vld_o(byte_vld), .overrun_o(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every byte strobe
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            n_bytes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R1/R6 unexpected byte", byte_out, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(byte_out == e, "R4 byte value", byte_out, e);
            end
        end
    end

    // Driver: one write strobe, then 16 cycles of ready observation.
    task automatic wr_cycle(input logic [7:0] d, input bit sel_pins_n, input bit sel_pin,
                            input bit expect_take, input bit extra_wr, input bit rd_inside,
                            output int lows, output int first_low);
        lows = 0; first_low = -1;
        @(negedge clk);
        sel_n = sel_pins_n; sel = sel_pin; data = d; wr_n = 1'b0;
        if (expect_take) exp_q.push_back(d);
        repeat (3) @(negedge clk);
        wr_n = 1'b1; data = ~d;                  // bus changes with the rising edge
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (!ready) begin
                lows++;
                if (first_low < 0) first_low = i;
            end
            if (rd_inside && i == 5) begin
                rd_oe_smp = d7_oe; rd_d7_smp = d7;
            end
            if (extra_wr && i == 1) wr_n = 1'b0;
            if (extra_wr && i == 3) wr_n = 1'b1;
            if (rd_inside && i == 1) rd_n = 1'b0;
            if (rd_inside && i == 6) rd_n = 1'b1;
        end
        sel_n = 1'b1; sel = 1'b0;
    endtask

    task automatic status_read(input bit sel_pins_n, input bit sel_pin,
                               output logic oe, output logic v);
        @(negedge clk);
        sel_n = sel_pins_n; sel = sel_pin; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        oe = d7_oe; v = d7;
        rd_n = 1'b1; sel_n = 1'b1; sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int lows, first;
        int nb;
        logic oe, v;
        logic [7:0] vals [4];
        vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF; vals[3] = 8'h00;

        rst_n = 1'b0; cfg_rst_n = 1'b0; sel_n = 1'b1; sel = 1'b0;
        wr_n = 1'b1; rd_n = 1'b1; data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(status_low == 1'b1, "R1 status pulled low in hold", status_low, 1);
        chk(ready == 1'b0, "R1 ready low in hold", ready, 0);
        chk(overrun == 1'b0, "R1 overrun clear", overrun, 0);
        chk(d7_oe == 1'b0, "R7 d7 not driven at reset", d7_oe, 0);

        // R1: write while held in configuration reset gives nothing
        nb = n_bytes;
        wr_cycle(8'h77, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, lows, first);
        chk(n_bytes == nb, "R1 no byte while held", n_bytes, nb);

        // R2: release
        @(negedge clk); cfg_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(status_low == 1'b0, "R2 status released", status_low, 0);
        chk(ready == 1'b1, "R2 ready after release", ready, 1);

        // R4 R5 R9: normal writes
        foreach (vals[k]) begin
            wr_cycle(vals[k], 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, lows, first);
            chk(first == 3, "R9 ready falls on third edge", first, 3);
            chk(lows == BUSY, "R5 busy length", lows, BUSY);
        end

        // R3: half-selected combinations are ignored
        nb = n_bytes;
        wr_cycle(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, lows, first);
        chk(lows == 0, "R3 sel_n high keeps ready", lows, 0);
        wr_cycle(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, lows, first);
        chk(lows == 0, "R3 sel low keeps ready", lows, 0);
        chk(n_bytes == nb, "R3 no byte when deselected", n_bytes, nb);
        chk(overrun == 1'b0, "R6 overrun still clear", overrun, 0);

        // R7: status reads
        status_read(1'b0, 1'b1, oe, v);
        chk(oe == 1'b1, "R7 d7 driven on read", oe, 1);
        chk(v == 1'b1, "R7 d7 shows ready", v, 1);
        status_read(1'b1, 1'b0, oe, v);
        chk(oe == 1'b0, "R7 d7 quiet when deselected", oe, 0);
        wr_cycle(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, lows, first);
        chk(rd_oe_smp == 1'b1, "R7 d7 driven during busy", rd_oe_smp, 1);
        chk(rd_d7_smp == 1'b0, "R7 d7 shows busy", rd_d7_smp, 0);
        chk(lows == BUSY, "R5 busy length with read", lows, BUSY);

        // R6: second strobe inside the busy window
        nb = n_bytes;
        wr_cycle(8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, lows, first);
        chk(lows == BUSY, "R6 busy length unchanged", lows, BUSY);
        chk(n_bytes == nb + 1, "R6 only one byte", n_bytes, nb + 1);
        chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
        wr_cycle(8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, lows, first);
        chk(overrun == 1'b1, "R6 overrun sticky", overrun, 1);

        // R8: abort in the middle of busy
        @(negedge clk);
        sel_n = 1'b0; sel = 1'b1; data = 8'h69; wr_n = 1'b0;
        exp_q.push_back(8'h69);
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(ready == 1'b0, "R8 busy before abort", ready, 0);
        cfg_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(status_low == 1'b1, "R8 status low after abort", status_low, 1);
        chk(ready == 1'b0, "R8 ready low after abort", ready, 0);
        repeat (8) @(negedge clk);
        chk(ready == 1'b0, "R8 stays held", ready, 0);
        chk(overrun == 1'b0, "R6 overrun cleared by hold", overrun, 0);
        sel_n = 1'b1; sel = 1'b0;
        cfg_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R2 ready after second release", ready, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule